// File: doc/BRIEF.md
# Parallel flash command sequencer

This block decodes the write side of a parallel NOR flash that uses the classic unlock-cycle command set. The host issues bus writes that carry a byte address and a data byte. The block turns the byte address into a word offset and follows the multi-write command sequences: two unlock writes, then a command write, then any further writes the command needs. It carries out program and erase operations on a synchronous single-port storage array through a plain address, write-data, write-enable and read-data port.

A program clears bits only. It reads the addressed word, ANDs it with the supplied byte and writes the result back. An erase sweeps 0xFF over one sector or over the whole array. While the erase runs, a delay counter models the device's completion time. A two-bit mode output tells the read path what a read should return: array data, identification data, status, or the query table. An unlock-bypass mode shortens repeated programming to two writes per byte.

Top module: `nor_cmd_seq`

## Requirements
- R1: The word offset is the byte address shifted right by 1 for a 2-byte device (the default), by 2 for a 4-byte device, and not shifted for a 1-byte device. Address bits below the word are ignored. Command addresses are compared on the low 11 bits of the word offset.
- R2: An unlock pair is data 0xAA at offset 0x555, then data 0x55 at offset 0x2AA. Any other write in place of either one returns the block to array read.
- R3: After an unlock pair, a write at offset 0x555 selects the command by its data. 0x80 starts erase setup, 0x90 enters autoselect, 0xA0 waits for program data, and 0x20 enters unlock bypass. Any other code or address returns the block to array read.
- R4: A write of data 0xF0 returns the block to array read and clears bypass from every non-busy state except the wait for program data. In that state the byte is taken as program data.
- R5: The program data write stores old AND new at the word offset. It does this through one read cycle and then one write cycle. Busy is high for the one cycle after the data write. The block then returns to array read, or to the command write when bypass is set.
- R6: Erase setup needs a second unlock pair. Data 0x10 at 0x555 then erases the whole array to 0xFF. Data 0x30 at any address erases to 0xFF the sector that holds that address, with the address aligned down to the sector size. Any other write returns the block to array read.
- R7: Busy rises on the cycle after the erase command and stays high for max(words swept, delay)+1 cycles. The delay is DLY_SECT for a sector and 10×DLY_SECT for the chip. Every bus write received while busy is ignored, 0xF0 included.
- R8: In bypass, the command write is accepted at any address. A completed program returns to the command write. Data 0x90 followed by data 0x00 leaves bypass and returns to array read.
- R9: Data 0x98 at offset 0x55 enters query mode, either from array read or from autoselect. Any write in query mode returns the block to array read.
- R10: The mode output is 0 for array read, 1 for autoselect, 2 for status (whenever busy), and 3 for query.
- R11: Reset leaves the block in array read with bypass clear, busy low and no storage write. An unknown internal state also returns to array read with bypass clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | MA_W+SHIFT | Byte address of the bus write |
| wr_data | input | 8 | Data byte of the bus write |
| mem_addr | output | MA_W | Storage word address |
| mem_wdata | output | 8 | Storage write data |
| mem_we | output | 1 | Storage write enable |
| mem_rdata | input | 8 | Storage read data, one cycle after the address |
| busy | output | 1 | Program or erase in progress |
| mode | output | 2 | Read-path mode (R10) |

## Verification
The bench attacks the places where the sequence can be misread. An unlock pair with the wrong data in its second write must not reach the command stage. A command written at the wrong address must be refused outside bypass. A 0xF0 sent as program data must be stored rather than treated as a reset. A design that got any of these wrong would show a wrong mode, or a storage word that differs after the next quiet period. Writes sent while an erase is busy, 0xF0 and a full command among them, must leave no trace; a design that accepted them would leave the mode or the array altered. The bench also checks the sector boundary and the busy length for both erase kinds. An off-by-one sweep would corrupt a neighbouring word, and a wrong delay shows up as a busy mismatch on the exact cycle.

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int DEV_BYTES = 2,
  parameter int MA_W      = 12,
  parameter int SECT_W    = 8,
  parameter int DLY_SECT  = 300,
  localparam int SHIFT    = (DEV_BYTES == 4) ? 2 : (DEV_BYTES == 2) ? 1 : 0,
  localparam int BA_W     = MA_W + SHIFT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [BA_W-1:0] wr_addr,
  input  logic [7:0]      wr_data,
  output logic [MA_W-1:0] mem_addr,
  output logic [7:0]      mem_wdata,
  output logic            mem_we,
  input  logic [7:0]      mem_rdata,
  output logic            busy,
  output logic [1:0]      mode
);
  localparam int DLY_CHIP   = 10 * DLY_SECT;
  localparam int SECT_WORDS = 1 << SECT_W;

  typedef enum logic [3:0] {
    S_RD, S_UNL1, S_CMD, S_PROG, S_RMW, S_ES0, S_ES1, S_ESEL, S_ERASE, S_ASEL, S_CFI
  } st_t;

  st_t             st;
  logic            byp;
  logic [MA_W-1:0] pa, swp_addr;
  logic [7:0]      pd;
  logic [MA_W:0]   swp_cnt;
  logic [31:0]     dly;

  wire [MA_W-1:0] woff  = wr_addr[BA_W-1:SHIFT];
  wire [10:0]     lo    = woff[10:0];
  wire            at555 = (lo == 11'h555);
  wire            at2aa = (lo == 11'h2AA);
  wire            at55  = (lo == 11'h055);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_RD;
      byp      <= 1'b0;
      pa       <= '0;
      pd       <= '0;
      swp_addr <= '0;
      swp_cnt  <= '0;
      dly      <= '0;
    end else begin
      case (st)
        S_RMW: st <= byp ? S_CMD : S_RD;
        S_ERASE: begin
          if (swp_cnt != 0) begin
            swp_addr <= swp_addr + 1'b1;
            swp_cnt  <= swp_cnt - 1'b1;
          end
          if (dly != 0) dly <= dly - 1;
          if (swp_cnt == 0 && dly == 0) st <= byp ? S_CMD : S_RD;
        end
        default: if (wr_en) begin
          if (wr_data == 8'hF0 && st != S_PROG) begin
            st  <= S_RD;
            byp <= 1'b0;
          end else begin
            case (st)
              S_RD:
                if (at55 && wr_data == 8'h98) st <= S_CFI;
                else if (at555 && wr_data == 8'hAA) st <= S_UNL1;
                else begin st <= S_RD; byp <= 1'b0; end
              S_UNL1:
                if (at2aa && wr_data == 8'h55) st <= S_CMD;
                else begin st <= S_RD; byp <= 1'b0; end
              S_CMD:
                if (!byp && !at555) begin st <= S_RD; byp <= 1'b0; end
                else case (wr_data)
                  8'h20:   begin byp <= 1'b1; st <= S_CMD; end
                  8'h80:   st <= S_ES0;
                  8'h90:   st <= S_ASEL;
                  8'hA0:   st <= S_PROG;
                  default: begin st <= S_RD; byp <= 1'b0; end
                endcase
              S_PROG: begin
                pa <= woff;
                pd <= wr_data;
                st <= S_RMW;
              end
              S_ES0:
                if (at555 && wr_data == 8'hAA) st <= S_ES1;
                else begin st <= S_RD; byp <= 1'b0; end
              S_ES1:
                if (at2aa && wr_data == 8'h55) st <= S_ESEL;
                else begin st <= S_RD; byp <= 1'b0; end
              S_ESEL:
                if (wr_data == 8'h10 && at555) begin
                  st       <= S_ERASE;
                  swp_addr <= '0;
                  swp_cnt  <= {1'b1, {MA_W{1'b0}}};
                  dly      <= 32'(DLY_CHIP);
                end else if (wr_data == 8'h30) begin
                  st       <= S_ERASE;
                  swp_addr <= {woff[MA_W-1:SECT_W], {SECT_W{1'b0}}};
                  swp_cnt  <= (MA_W+1)'(SECT_WORDS);
                  dly      <= 32'(DLY_SECT);
                end else begin st <= S_RD; byp <= 1'b0; end
              S_ASEL:
                if (byp && wr_data == 8'h00) begin st <= S_RD; byp <= 1'b0; end
                else if (at55 && wr_data == 8'h98) st <= S_CFI;
                else begin st <= S_RD; byp <= 1'b0; end
              default: begin st <= S_RD; byp <= 1'b0; end
            endcase
          end
        end
      endcase
    end
  end

  assign busy      = (st == S_RMW) || (st == S_ERASE);
  assign mem_we    = (st == S_RMW) || (st == S_ERASE && swp_cnt != 0);
  assign mem_wdata = (st == S_ERASE) ? 8'hFF : (mem_rdata & pd);
  assign mem_addr  = (st == S_ERASE) ? swp_addr : (st == S_RMW) ? pa : woff;
  assign mode      = busy ? 2'd2 : (st == S_ASEL) ? 2'd1 : (st == S_CFI) ? 2'd3 : 2'd0;
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int MA_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [MA_W-1:0] mem_addr,
  input logic [7:0]      mem_wdata,
  input logic            mem_we,
  input logic            busy,
  input logic [1:0]      mode
);
  p_we_needs_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  p_busy_is_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> mode == 2'd2);

  p_sweep_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_wdata == 8'hFF);

  p_sweep_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_addr == MA_W'($past(mem_addr) + 1'b1));

  p_query_leave_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && wr_en) |=> mode == 2'd0);

  p_reset_quiet_r11: assert property (@(posedge clk)
    !rst_n |=> !busy && !mem_we);
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.MA_W(MA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_we(mem_we), .busy(busy), .mode(mode));

// File: tb/tb_nor_cmd_seq.sv
module tb_nor_cmd_seq;
  localparam int WORDS = 4096;
  localparam int SECT  = 256;
  localparam int DS    = 300;
  localparam int DC    = 3000;

  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [12:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [11:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_we, busy;
  logic [1:0]  mode;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] mem [WORDS];
  logic [7:0] exp_mem [WORDS];
  int m_ph = 0, m_busy = 0;
  bit m_byp = 0;

  always #4 clk = ~clk;

  nor_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
    .busy(busy), .mode(mode));

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  function automatic int m_mode();
    if (m_busy > 0) return 2;
    if (m_ph == 9) return 1;
    if (m_ph == 10) return 3;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_byp = 0; m_busy = 0;
    end else if (m_busy > 0) begin
      m_busy--;
      if (m_busy == 0) m_ph = m_byp ? 2 : 0;
    end else if (wr_en) begin
      int w, lo;
      w  = int'(wr_addr >> 1);
      lo = w & 'h7FF;
      if (wr_data == 8'hF0 && m_ph != 3) begin m_ph = 0; m_byp = 0; end
      else case (m_ph)
        0: if (lo == 'h55 && wr_data == 8'h98) m_ph = 10;
           else if (lo == 'h555 && wr_data == 8'hAA) m_ph = 1;
           else begin m_ph = 0; m_byp = 0; end
        1: if (lo == 'h2AA && wr_data == 8'h55) m_ph = 2; else begin m_ph = 0; m_byp = 0; end
        2: if (!m_byp && lo != 'h555) begin m_ph = 0; m_byp = 0; end
           else if (wr_data == 8'h20) m_byp = 1;
           else if (wr_data == 8'h80) m_ph = 5;
           else if (wr_data == 8'h90) m_ph = 9;
           else if (wr_data == 8'hA0) m_ph = 3;
           else begin m_ph = 0; m_byp = 0; end
        3: begin exp_mem[w] = exp_mem[w] & wr_data; m_busy = 1; end
        5: if (lo == 'h555 && wr_data == 8'hAA) m_ph = 6; else begin m_ph = 0; m_byp = 0; end
        6: if (lo == 'h2AA && wr_data == 8'h55) m_ph = 7; else begin m_ph = 0; m_byp = 0; end
        7: if (wr_data == 8'h10 && lo == 'h555) begin
             for (int i = 0; i < WORDS; i++) exp_mem[i] = 8'hFF;
             m_busy = ((WORDS > DC) ? WORDS : DC) + 1;
           end else if (wr_data == 8'h30) begin
             for (int i = 0; i < SECT; i++) exp_mem[(w / SECT) * SECT + i] = 8'hFF;
             m_busy = ((SECT > DS) ? SECT : DS) + 1;
           end else begin m_ph = 0; m_byp = 0; end
        9: if (m_byp && wr_data == 8'h00) begin m_ph = 0; m_byp = 0; end
           else if (lo == 'h55 && wr_data == 8'h98) m_ph = 10;
           else begin m_ph = 0; m_byp = 0; end
        default: begin m_ph = 0; m_byp = 0; end
      endcase
    end
  end

  // per-cycle comparison: mode (R10) and busy (R5, R7)
  always @(negedge clk) if (rst_n) begin
    cyc++;
    n_chk++;
    if (int'(mode) != m_mode() || busy != (m_busy > 0)) begin
      n_bad++;
      $display("FAIL R10/R7 cycle %0d: mode=%0d busy=%0b expected mode=%0d busy=%0b",
               cyc, mode, busy, m_mode(), m_busy > 0);
    end
  end

  task automatic wr(input int w, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = {w[11:0], d[0]}; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_mode(input int e, input string tag);
    n_chk++;
    if (int'(mode) != e) begin
      n_bad++;
      $display("FAIL %s: mode actual %0d expected %0d", tag, mode, e);
    end
  endtask

  task automatic chk_mem(input string tag);
    int bad = -1;
    n_chk++;
    for (int i = 0; i < WORDS; i++) if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
    if (bad >= 0) begin
      n_bad++;
      $display("FAIL %s: word %0h actual %0h expected %0h", tag, bad, mem[bad], exp_mem[bad]);
    end
  endtask

  task automatic unlock();
    wr('h555, 8'hAA); wr('h2AA, 8'h55);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin mem[i] = 8'(i * 37 + 5); exp_mem[i] = mem[i]; end
    idle(3);
    rst_n = 1;
    idle(2);
    // R11: reset state
    n_chk++;
    if (busy !== 0 || mode !== 0 || mem_we !== 0) begin
      n_bad++; $display("FAIL R11: busy=%0b mode=%0d we=%0b expected 0 0 0", busy, mode, mem_we);
    end
    // R5, R1: program
    unlock(); wr('h555, 8'hA0); wr('h100, 8'h0F);
    chk_mode(2, "R5 busy");
    idle(2); chk_mode(0, "R5 return"); chk_mem("R5 program AND");
    // R2: bad second unlock
    wr('h555, 8'hAA); wr('h2AA, 8'h56); wr('h555, 8'h90); chk_mode(0, "R2");
    // R3: command at wrong address, then unknown code
    unlock(); wr('h554, 8'h90); chk_mode(0, "R3 addr");
    unlock(); wr('h555, 8'h77); chk_mode(0, "R3 code");
    // R3, R9: autoselect then query
    unlock(); wr('h555, 8'h90); chk_mode(1, "R3 autoselect");
    wr('h055, 8'h98); chk_mode(3, "R9 from autoselect");
    wr('h123, 8'h00); chk_mode(0, "R9 leave");
    wr('h055, 8'h98); chk_mode(3, "R9 from read");
    wr('h055, 8'hF0); chk_mode(0, "R9 F0");
    // R4: F0 abort in erase setup; then 0x10 must not erase
    unlock(); wr('h555, 8'h80); wr('h555, 8'hAA); wr('h2AA, 8'hF0);
    wr('h555, 8'h10); idle(3); chk_mode(0, "R4 abort"); chk_mem("R4 no erase");
    // R4: F0 as program data
    unlock(); wr('h555, 8'hA0); wr('h200, 8'hF0); idle(3); chk_mem("R4 F0 data");
    // R6, R7: sector erase with writes during busy
    unlock(); wr('h555, 8'h80); unlock(); wr('h345, 8'h30);
    chk_mode(2, "R7 sector busy");
    wr('h555, 8'hF0); unlock(); wr('h555, 8'hA0); wr('h310, 8'h00);
    idle(DS + 5); chk_mode(0, "R7 sector done"); chk_mem("R6 sector fill");
    // R8: bypass
    unlock(); wr('h555, 8'h20); chk_mode(0, "R8 enter");
    wr('h123, 8'hA0); wr('h050, 8'h3C); idle(2); chk_mem("R8 program any addr");
    wr('h777, 8'hA0); wr('h051, 8'h81); idle(2); chk_mem("R8 repeat program");
    wr('h000, 8'h90); chk_mode(1, "R8 90");
    wr('h000, 8'h00); chk_mode(0, "R8 exit");
    unlock(); wr('h123, 8'hA0); wr('h060, 8'h00); idle(2); chk_mem("R8 address check back");
    // R6, R7: chip erase
    unlock(); wr('h555, 8'h80); unlock(); wr('h555, 8'h10);
    idle(DC); chk_mode(2, "R7 chip still busy");
    idle(WORDS - DC + 5); chk_mode(0, "R7 chip done"); chk_mem("R6 chip fill");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule